// File: doc/BRIEF.md
# UART Loopback Signal Router

This block sits between a UART's core logic and its device pins. It routes the serial data and the modem handshake signals so that the UART can test itself on the board. In normal operation the transmit stream goes to the TX pin and the RX pin feeds the receiver. The DTR and RTS control bits drive their pins. The four external status inputs are synchronised and passed on to the modem status logic.

When loopback is enabled, the block isolates the external side. The transmit stream is turned back into the receiver and the TX pin rests at mark. DTR and RTS are forced inactive. The four modem control bits stand in for the status inputs. The block also produces a per-bit change pulse on whichever status source is selected. Toggling a control bit in loopback therefore exercises the same change-detect and interrupt path that a pin transition would. A change of mode reloads the status copy without raising a change pulse.

All levels are active high inside the block. Status bit order is CTS = bit 0, DSR = bit 1, RI = bit 2, CD = bit 3. Control bit order is DTR = bit 0, RTS = bit 1, OP1 = bit 2, OP2 = bit 3.

Top module: `uart_loop_switch`

## Requirements
- R1: With `loopEn` high, `rxSerial` equals `txSerial` and `rxPin` has no effect. With `loopEn` low, `rxSerial` equals `rxPin`.
- R2: With `loopEn` low, `txPin` equals `txSerial`. With `loopEn` high, `txPin` is 1 (mark).
- R3: With `loopEn` low, `dtrPin` equals `ctrlBits[0]` and `rtsPin` equals `ctrlBits[1]`. With `loopEn` high, both pins are 0 (inactive).
- R4: When `loopEn` is high at a rising edge, `statusOut` takes these values after that edge: CTS (bit 0) from DTR `ctrlBits[0]`, DSR (bit 1) from RTS `ctrlBits[1]`, RI (bit 2) from OP1 `ctrlBits[2]`, CD (bit 3) from OP2 `ctrlBits[3]`. `modemPins` has no effect in this mode.
- R5: With `loopEn` low, each `statusOut` bit follows the same bit of `modemPins` after SYNC_STAGES+1 rising edges (3 by default).
- R6: Outside a reload, `deltaOut[i]` is 1 for exactly the one cycle in which `statusOut[i]` takes a new value, and is 0 otherwise. This holds in both modes.
- R7: At a rising edge where `loopEn` differs from its value at the previous edge, `statusOut` is loaded from the newly selected source and `deltaOut` is all zero for the following cycle.
- R8: During reset `statusOut` and `deltaOut` are 0. For the first SYNC_STAGES+1 rising edges after reset the status is loaded from the selected source and no change pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loopEn | input | 1 | Loopback enable |
| ctrlBits | input | 4 | Modem control bits: DTR, RTS, OP1, OP2 (bit 0..3) |
| txSerial | input | 1 | Serial output of the transmitter |
| rxPin | input | 1 | External receive pin |
| modemPins | input | 4 | External CTS, DSR, RI, CD (bit 0..3), asynchronous |
| rxSerial | output | 1 | Serial input to the receiver |
| txPin | output | 1 | External transmit pin |
| dtrPin | output | 1 | External DTR, 1 = asserted |
| rtsPin | output | 1 | External RTS, 1 = asserted |
| statusOut | output | 4 | Selected status: CTS, DSR, RI, CD (bit 0..3) |
| deltaOut | output | 4 | One-cycle change pulse per status bit |

## Verification
The assertions take `loopEn` and `ctrlBits` to be synchronous to `clk`. They also take it that the change-pulse check runs only in cycles where a new value has settled, which means no reload is in progress. `modemPins` may be asynchronous because it passes through the synchroniser. The properties on it therefore compare only the synchronised result. The bench drives every input on the falling edge only, so each input is stable at the rising edge. It changes `loopEn` rarely and the control and pin values often. This yields long runs in each mode, with mode switches both right after and far from status changes.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;
  localparam int NUM_STAT = 4;

  // control bit positions
  localparam int CTRL_DTR = 0;
  localparam int CTRL_RTS = 1;
  localparam int CTRL_OP1 = 2;
  localparam int CTRL_OP2 = 3;

  // status bit positions
  localparam int STAT_CTS = 0;
  localparam int STAT_DSR = 1;
  localparam int STAT_RI  = 2;
  localparam int STAT_CD  = 3;

  typedef struct packed {
    logic reload;      // load status copy without raising deltas
    logic loopActive;  // loopback routing selected
  } loopStrobe_t;
endpackage

// File: rtl/uart_loop_ctrl.sv
module uart_loop_ctrl
  import uart_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loopEn,
  output loopStrobe_t strobe
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);
  localparam logic [CW-1:0] WARM_C = CW'(WARM);

  logic [CW-1:0] warmCnt;
  logic          loopQ;

  // warm-up: the synchroniser holds stale data for its first edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
      loopQ   <= 1'b0;
    end else begin
      loopQ <= loopEn;
      if (warmCnt != WARM_C) warmCnt <= warmCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.loopActive = loopEn;
    strobe.reload     = (warmCnt != WARM_C) || (loopEn != loopQ);
  end
endmodule

// File: rtl/uart_loop_datapath.sv
module uart_loop_datapath
  import uart_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  loopStrobe_t         strobe,
  input  logic [NUM_STAT-1:0] ctrlBits,
  input  logic                txSerial,
  input  logic                rxPin,
  input  logic [NUM_STAT-1:0] modemPins,
  output logic                rxSerial,
  output logic                txPin,
  output logic                dtrPin,
  output logic                rtsPin,
  output logic [NUM_STAT-1:0] statusOut,
  output logic [NUM_STAT-1:0] deltaOut
);
  logic [NUM_STAT-1:0] syncQ [SYNC_STAGES];
  logic [NUM_STAT-1:0] loopSrc;
  logic [NUM_STAT-1:0] selSrc;
  logic [NUM_STAT-1:0] statusQ;
  logic [NUM_STAT-1:0] deltaQ;

  // synchroniser chain on the external status pins
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= '0;
        else       syncQ[0] <= modemPins;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  // loopback wiring of control bits onto status inputs
  always_comb begin
    loopSrc           = '0;
    loopSrc[STAT_CTS] = ctrlBits[CTRL_DTR];
    loopSrc[STAT_DSR] = ctrlBits[CTRL_RTS];
    loopSrc[STAT_RI]  = ctrlBits[CTRL_OP1];
    loopSrc[STAT_CD]  = ctrlBits[CTRL_OP2];
  end

  assign selSrc = strobe.loopActive ? loopSrc : syncQ[SYNC_STAGES-1];

  // status copy and change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      deltaQ  <= '0;
    end else begin
      statusQ <= selSrc;
      deltaQ  <= strobe.reload ? '0 : (selSrc ^ statusQ);
    end
  end

  // serial and pin routing
  always_comb begin
    rxSerial = strobe.loopActive ? txSerial : rxPin;
    txPin    = strobe.loopActive ? 1'b1 : txSerial;
    dtrPin   = strobe.loopActive ? 1'b0 : ctrlBits[CTRL_DTR];
    rtsPin   = strobe.loopActive ? 1'b0 : ctrlBits[CTRL_RTS];
  end

  assign statusOut = statusQ;
  assign deltaOut  = deltaQ;
endmodule

// File: rtl/uart_loop_switch.sv
module uart_loop_switch
  import uart_loop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopEn,
  input  logic [3:0] ctrlBits,
  input  logic       txSerial,
  input  logic       rxPin,
  input  logic [3:0] modemPins,
  output logic       rxSerial,
  output logic       txPin,
  output logic       dtrPin,
  output logic       rtsPin,
  output logic [3:0] statusOut,
  output logic [3:0] deltaOut
);
  loopStrobe_t strobe;

  uart_loop_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .loopEn (loopEn),
    .strobe (strobe)
  );

  uart_loop_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ctrlBits  (ctrlBits),
    .txSerial  (txSerial),
    .rxPin     (rxPin),
    .modemPins (modemPins),
    .rxSerial  (rxSerial),
    .txPin     (txPin),
    .dtrPin    (dtrPin),
    .rtsPin    (rtsPin),
    .statusOut (statusOut),
    .deltaOut  (deltaOut)
  );
endmodule

// File: rtl/uart_loop_switch_checker.sv
module uart_loop_switch_checker (
  input logic       clk,
  input logic       rstN,
  input logic       loopEn,
  input logic [3:0] ctrlBits,
  input logic       txSerial,
  input logic       rxPin,
  input logic [3:0] modemPins,
  input logic       rxSerial,
  input logic       txPin,
  input logic       dtrPin,
  input logic       rtsPin,
  input logic [3:0] statusOut,
  input logic [3:0] deltaOut
);
  a_r1_loop_rx: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> (rxSerial == txSerial));

  a_r2_tx_mark: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> txPin);

  a_r3_pins_idle: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> (!dtrPin && !rtsPin));

  a_r4_loop_map: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> (statusOut == {$past(ctrlBits[3]), $past(ctrlBits[2]),
                              $past(ctrlBits[1]), $past(ctrlBits[0])}));

  a_r6_delta_match: assert property (@(posedge clk) disable iff (!rstN)
    (deltaOut != 4'b0) |-> (deltaOut == (statusOut ^ $past(statusOut))));

  a_r7_switch_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn != $past(loopEn)) |=> (deltaOut == 4'b0));
endmodule

bind uart_loop_switch uart_loop_switch_checker u_chk (.*);

// File: tb/uart_loop_switch_test.sv
module uart_loop_switch_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loopEn = 1'b0;
  logic [3:0] ctrlBits = '0;
  logic       txSerial = 1'b1;
  logic       rxPin = 1'b1;
  logic [3:0] modemPins = '0;
  logic       rxSerial, txPin, dtrPin, rtsPin;
  logic [3:0] statusOut, deltaOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [3:0] pinHist [SYNC];
  logic [3:0] expStatus = '0;
  logic [3:0] expDelta = '0;
  logic       prevLoop = 1'b0;
  int         edgesSinceReset = 0;

  uart_loop_switch uut (
    .clk(clk), .rstN(rstN), .loopEn(loopEn), .ctrlBits(ctrlBits),
    .txSerial(txSerial), .rxPin(rxPin), .modemPins(modemPins),
    .rxSerial(rxSerial), .txPin(txPin), .dtrPin(dtrPin), .rtsPin(rtsPin),
    .statusOut(statusOut), .deltaOut(deltaOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] loopMap(input logic [3:0] c);
    // CTS<-DTR, DSR<-RTS, RI<-OP1, CD<-OP2
    return {c[3], c[2], c[1], c[0]};
  endfunction

  function automatic logic expRx(input logic l, input logic t, input logic r);
    return l ? t : r;
  endfunction

  // combinational outputs, checked just after inputs settle
  task automatic checkComb();
    #1;
    check("R1 rxSerial", {3'b0, rxSerial}, {3'b0, expRx(loopEn, txSerial, rxPin)});
    check("R2 txPin", {3'b0, txPin}, {3'b0, loopEn ? 1'b1 : txSerial});
    check("R3 dtrPin", {3'b0, dtrPin}, {3'b0, loopEn ? 1'b0 : ctrlBits[0]});
    check("R3 rtsPin", {3'b0, rtsPin}, {3'b0, loopEn ? 1'b0 : ctrlBits[1]});
  endtask

  // one clock: inputs already driven at negedge; update reference at posedge
  task automatic step(input string tag);
    logic [3:0] src;
    logic       reload;
    checkComb();
    @(posedge clk);
    src    = loopEn ? loopMap(ctrlBits) : pinHist[SYNC-1];
    reload = (edgesSinceReset < SYNC + 1) || (loopEn != prevLoop);
    expDelta  = reload ? 4'b0 : (src ^ expStatus);
    expStatus = src;
    for (int s = SYNC - 1; s > 0; s--) pinHist[s] = pinHist[s-1];
    pinHist[0] = modemPins;
    prevLoop = loopEn;
    edgesSinceReset++;
    @(negedge clk);
    check({tag, " R4/R5 statusOut"}, statusOut, expStatus);
    check({tag, " R6/R7 deltaOut"}, deltaOut, expDelta);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    for (int s = 0; s < SYNC; s++) pinHist[s] = '0;

    // R8 reset state with pins active
    modemPins = 4'hF;
    ctrlBits  = 4'hF;
    repeat (3) @(negedge clk);
    check("R8 reset statusOut", statusOut, 4'h0);
    check("R8 reset deltaOut", deltaOut, 4'h0);
    rstN = 1'b1;

    // R8 warm-up: no delta while the pin value propagates
    repeat (SYNC + 3) step("R8 warm");

    // R5 pin change latency, R6 single pulse
    modemPins = 4'h5;
    repeat (SYNC + 3) step("R5 pins");

    // R7 enter loopback with differing source: no delta
    ctrlBits = 4'h0;
    loopEn = 1'b1;
    step("R7 enter");
    // R4 each control bit individually, R1 rxPin ignored
    for (int b = 0; b < 4; b++) begin
      ctrlBits = 4'(1 << b);
      rxPin = ~rxPin;
      modemPins = ~modemPins;
      step("R4 bit");
    end
    // R7 leave loopback
    loopEn = 1'b0;
    step("R7 leave");
    step("R7 after");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) loopEn = ~loopEn;
      if ($urandom_range(0, 3) == 0) ctrlBits = 4'($urandom);
      if ($urandom_range(0, 3) == 0) modemPins = 4'($urandom);
      txSerial = 1'($urandom);
      rxPin = 1'($urandom);
      step("rand");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule